// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

This block rearranges bytes between two 128-bit data vectors. Each of the sixteen result bytes may be taken from any of the thirty-two bytes in the pair of sources. In general permute mode, a third 128-bit vector supplies one selector per result byte. The unit also has two fixed rearrangements. Splat copies one element of the first source into every element position. Merge interleaves elements taken from the same half of both sources.

Splat and merge do not have their own datapath. A small generator builds an internal selector vector for them, and that vector drives the same byte crossbar that general permute uses. One operation can be accepted on every clock. Each result appears one cycle after its operation is accepted, and there is no backpressure. The unit is an execution slice: it does not fetch its operands and it does not store its results.

Top module: `vperm_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low in every other cycle. While `rst` is high and after it, both `out_valid` and `result` are zero until the first accepted operation.
- R2: In permute mode (`op_mode` = 0), result byte j is byte `ctrl_j[4:0]` of the 32-byte pool. Pool bytes 0–15 are `src_a` and pool bytes 16–31 are `src_b`. Byte 0 of any vector is bits 127:120, and byte k of any vector is bits 127-8k down to 120-8k.
- R3: In permute mode, bits 7:5 of each control byte have no effect on the result.
- R4: In splat mode (`op_mode` = 1), every element of the result equals element `splat_sel` of `src_a`. The element size is set by `elem_size`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits.
- R5: For 16-bit and 32-bit splats, `splat_sel` is taken modulo the number of elements. Only its low 3 or low 2 bits are used.
- R6: In merge-high mode (`op_mode` = 2), with n elements per vector at the size given by `elem_size`, result element 2e is element e of `src_a` and result element 2e+1 is element e of `src_b`, for e from 0 to n/2-1.
- R7: In merge-low mode (`op_mode` = 3), result element 2e is element n/2+e of `src_a` and result element 2e+1 is element n/2+e of `src_b`.
- R8: In splat and merge modes, `ctrl` has no effect on the result.
- R9: In any cycle where `in_valid` is low, `result` keeps its value regardless of the other inputs.
- R10: Operations can be issued on consecutive cycles. Each result appears exactly one cycle after its operation is accepted, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_mode | input | 2 | 0 permute, 1 splat, 2 merge-high, 3 merge-low |
| elem_size | input | 2 | Element size for splat and merge: 0 is 8-bit, 1 is 16-bit, 2 and 3 are 32-bit |
| splat_sel | input | 4 | Element index for splat |
| src_a | input | 128 | First data vector (pool bytes 0–15) |
| src_b | input | 128 | Second data vector (pool bytes 16–31) |
| ctrl | input | 128 | Per-byte selector vector for permute mode |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Rearranged vector |

## Verification
The assertions check several properties on every cycle:
- the one-cycle valid timing;
- that the result holds in idle cycles;
- that the leading result byte of each permute follows its selector;
- that a byte splat makes all result bytes equal;
- the position of the first byte taken from each source in byte merges.

Several behaviours are shown only by the bench's scenarios, which compare every result byte with a behavioural model on every clock:
- the full byte mapping for each mode and element size;
- the modulo reduction of the splat index;
- that the upper selector bits are ignored;
- that the control vector is ignored outside permute mode.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int unsigned VP_BYTE_W = 8;

    typedef enum logic [1:0] {
        VP_PERM   = 2'd0,
        VP_SPLAT  = 2'd1,
        VP_MRG_HI = 2'd2,
        VP_MRG_LO = 2'd3
    } vp_mode_e;

    typedef enum logic [1:0] {
        VP_E8   = 2'd0,
        VP_E16  = 2'd1,
        VP_E32  = 2'd2,
        VP_E32X = 2'd3
    } vp_esize_e;

    // Operation descriptor carried from the ports into the selector generator.
    typedef struct packed {
        vp_mode_e  mode;
        vp_esize_e esize;
    } vp_op_t;

    function automatic int unsigned esize_bytes(vp_esize_e s);
        case (s)
            VP_E8:   return 1;
            VP_E16:  return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/vperm_ctrl_gen.sv
module vperm_ctrl_gen
    import vperm_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned IDX_W = $clog2(2 * LANES),
    parameter int unsigned SPL_W = $clog2(LANES)
) (
    input  vp_op_t                       op,
    input  logic [SPL_W-1:0]             spl_idx,
    input  logic [LANES*VP_BYTE_W-1:0]   user_ctrl,
    output logic [LANES*IDX_W-1:0]       sel
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        always_comb begin
            int unsigned sb;
            int unsigned n;
            int unsigned e;
            int unsigned k;
            int unsigned base;
            int unsigned pick;
            sb   = esize_bytes(op.esize);
            n    = LANES / sb;
            e    = j / sb;
            k    = j % sb;
            base = (op.mode == VP_MRG_LO) ? n / 2 : 0;
            case (op.mode)
                VP_PERM:  pick = 32'(user_ctrl[(LANES-1-j)*VP_BYTE_W +: IDX_W]);
                VP_SPLAT: pick = (32'(spl_idx) % n) * sb + k;
                default:  pick = (e % 2) * LANES + (base + e / 2) * sb + k;
            endcase
            sel[j*IDX_W +: IDX_W] = IDX_W'(pick);
        end
    end

endmodule

// File: rtl/vperm_xbar.sv
module vperm_xbar
    import vperm_pkg::*;
#(
    parameter int unsigned LANES = 16,
    parameter int unsigned IDX_W = $clog2(2 * LANES)
) (
    input  logic [LANES*VP_BYTE_W-1:0] vec_a,
    input  logic [LANES*VP_BYTE_W-1:0] vec_b,
    input  logic [LANES*IDX_W-1:0]     sel,
    output logic [LANES*VP_BYTE_W-1:0] vec_y
);

    localparam int unsigned POOL = 2 * LANES;

    logic [VP_BYTE_W-1:0] pool [POOL];

    // Pool byte 0 is the most significant byte of vec_a.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            pool[k]         = vec_a[(LANES-1-k)*VP_BYTE_W +: VP_BYTE_W];
            pool[k + LANES] = vec_b[(LANES-1-k)*VP_BYTE_W +: VP_BYTE_W];
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_out
        assign vec_y[(LANES-1-j)*VP_BYTE_W +: VP_BYTE_W] = pool[sel[j*IDX_W +: IDX_W]];
    end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
#(
    parameter int unsigned LANES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [1:0]                   op_mode,
    input  logic [1:0]                   elem_size,
    input  logic [$clog2(LANES)-1:0]     splat_sel,
    input  logic [LANES*8-1:0]           src_a,
    input  logic [LANES*8-1:0]           src_b,
    input  logic [LANES*8-1:0]           ctrl,
    output logic                         out_valid,
    output logic [LANES*8-1:0]           result
);

    localparam int unsigned VEC_W = LANES * VP_BYTE_W;
    localparam int unsigned IDX_W = $clog2(2 * LANES);
    localparam int unsigned SPL_W = $clog2(LANES);

    vp_op_t                   op;
    logic [LANES*IDX_W-1:0]   sel;
    logic [VEC_W-1:0]         perm_y;

    assign op.mode  = vp_mode_e'(op_mode);
    assign op.esize = vp_esize_e'(elem_size);

    vperm_ctrl_gen #(.LANES(LANES), .IDX_W(IDX_W), .SPL_W(SPL_W)) u_gen (
        .op        (op),
        .spl_idx   (splat_sel),
        .user_ctrl (ctrl),
        .sel       (sel)
    );

    vperm_xbar #(.LANES(LANES), .IDX_W(IDX_W)) u_xbar (
        .vec_a (src_a),
        .vec_b (src_b),
        .sel   (sel),
        .vec_y (perm_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= perm_y;
            end
        end
    end

endmodule

// File: rtl/vperm_chk.sv
module vperm_chk #(
    parameter int unsigned LANES = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [1:0]                op_mode,
    input logic [1:0]                elem_size,
    input logic [$clog2(LANES)-1:0]  splat_sel,
    input logic [LANES*8-1:0]        src_a,
    input logic [LANES*8-1:0]        src_b,
    input logic [LANES*8-1:0]        ctrl,
    input logic                      out_valid,
    input logic [LANES*8-1:0]        result
);

    localparam int unsigned VEC_W = LANES * 8;
    localparam int unsigned IDX_W = $clog2(2 * LANES);

    function automatic logic [7:0] pool_byte(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
                                             logic [IDX_W-1:0] idx);
        logic [2*VEC_W-1:0] cat;
        cat = {a, b};
        return cat[(2*LANES-1-int'(idx))*8 +: 8];
    endfunction

    // R1: valid appears one cycle after acceptance
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1: no valid without a preceding acceptance
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: idle cycles leave the result untouched
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R2: leading byte follows its selector
    p_perm_lead_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_mode == 2'd0) |=>
        result[VEC_W-1 -: 8] == pool_byte($past(src_a), $past(src_b),
                                          $past(ctrl[VEC_W-8 +: IDX_W])));

    // R4: byte splat makes all bytes equal
    p_splat8_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_mode == 2'd1 && elem_size == 2'd0) |=>
        result == {LANES{result[7:0]}});

    // R6: byte merge-high places the first byte of the second source at byte 1
    p_mrghi_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_mode == 2'd2 && elem_size == 2'd0) |=>
        result[VEC_W-9 -: 8] == $past(src_b[VEC_W-1 -: 8]));

    // R7: byte merge-low starts with the middle byte of the first source
    p_mrglo_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_mode == 2'd3 && elem_size == 2'd0) |=>
        result[VEC_W-1 -: 8] == $past(src_a[(LANES/2-1)*8 +: 8]));

endmodule

bind vperm_unit vperm_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_mode   (op_mode),
    .elem_size (elem_size),
    .splat_sel (splat_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .ctrl      (ctrl),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_vperm_unit.sv
module tb_vperm_unit;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   op_mode;
    logic [1:0]   elem_size;
    logic [3:0]   splat_sel;
    logic [127:0] src_a, src_b, ctrl;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;

    logic         exp_v;
    logic [127:0] exp_r;
    string        exp_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    vperm_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_mode(op_mode),
        .elem_size(elem_size), .splat_sel(splat_sel), .src_a(src_a),
        .src_b(src_b), .ctrl(ctrl), .out_valid(out_valid), .result(result)
    );

    // Behavioural model written from the requirements.
    function automatic logic [127:0] model(logic [1:0] m, logic [1:0] s, logic [3:0] idx,
                                           logic [127:0] a, logic [127:0] b, logic [127:0] c);
        logic [7:0]   pool [32];
        logic [127:0] y;
        int sb, n;
        sb = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
        n  = 16 / sb;
        for (int k = 0; k < 16; k++) begin
            pool[k]      = a[127-8*k -: 8];
            pool[16 + k] = b[127-8*k -: 8];
        end
        for (int j = 0; j < 16; j++) begin
            int src;
            int e;
            e = j / sb;
            if (m == 2'd0)
                src = int'(c[127-8*j -: 8]) % 32;
            else if (m == 2'd1)
                src = (int'(idx) % n) * sb + (j % sb);
            else if (e % 2 == 0)
                src = ((m == 2'd2 ? 0 : n/2) + e/2) * sb + (j % sb);
            else
                src = 16 + ((m == 2'd2 ? 0 : n/2) + e/2) * sb + (j % sb);
            y[127-8*j -: 8] = pool[src];
        end
        return y;
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_v || result !== exp_r) begin
            fails++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     exp_req, out_valid, result, exp_v, exp_r);
        end
    endtask

    task automatic step(input string req, input logic v, input logic [1:0] m,
                        input logic [1:0] s, input logic [3:0] idx,
                        input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
        @(negedge clk);
        compare();
        in_valid  = v;
        op_mode   = m;
        elem_size = s;
        splat_sel = idx;
        src_a     = a;
        src_b     = b;
        ctrl      = c;
        exp_v     = v;
        exp_req   = req;
        if (v) exp_r = model(m, s, idx, a, b, c);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic [127:0] seq_ctrl(int start, int stride);
        logic [127:0] c;
        for (int j = 0; j < 16; j++) c[127-8*j -: 8] = 8'((start + stride*j) % 32);
        return c;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [127:0] va, vb, vc;

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_mode = '0; elem_size = '0; splat_sel = '0;
        src_a = '0; src_b = '0; ctrl = '0;
        exp_v = 1'b0; exp_r = '0; exp_req = "R1";
        repeat (3) @(negedge clk);
        compare();                     // R1 reset state
        rst = 1'b0;
        va = 128'h000102030405060708090a0b0c0d0e0f;
        vb = 128'h101112131415161718191a1b1c1d1e1f;
        step("R1", 1'b0, 2'd0, 2'd0, 4'd0, va, vb, '0);
        // R2: identity, reverse, all-from-B, random selectors
        step("R2", 1'b1, 2'd0, 2'd0, 4'd0, va, vb, seq_ctrl(0, 1));
        step("R2", 1'b1, 2'd0, 2'd0, 4'd0, va, vb, seq_ctrl(31, 31));
        step("R2", 1'b1, 2'd0, 2'd0, 4'd0, rnd128(), rnd128(), seq_ctrl(16, 1));
        for (int i = 0; i < 20; i++)
            step("R2", 1'b1, 2'd0, 2'd0, 4'd0, rnd128(), rnd128(),
                 rnd128() & {16{8'h1f}});
        // R3: same selectors with random upper bits
        vc = rnd128() & {16{8'h1f}};
        step("R3", 1'b1, 2'd0, 2'd0, 4'd0, va, vb, vc | {16{8'he0}});
        step("R3", 1'b1, 2'd0, 2'd0, 4'd0, va, vb, vc | (rnd128() & {16{8'he0}}));
        for (int i = 0; i < 10; i++)
            step("R3", 1'b1, 2'd0, 2'd0, 4'd0, rnd128(), rnd128(), rnd128());
        // R4/R5: splat at all sizes, edge and wrapping indices
        for (int s = 0; s < 4; s++) begin
            step("R4", 1'b1, 2'd1, 2'(s), 4'd0, rnd128(), rnd128(), '0);
            step("R4", 1'b1, 2'd1, 2'(s), 4'd15, rnd128(), rnd128(), '0);
            step("R5", 1'b1, 2'd1, 2'(s), 4'd9, rnd128(), rnd128(), '0);
            step("R5", 1'b1, 2'd1, 2'(s), 4'd6, va, vb, '0);
        end
        // R6/R7: merges at all sizes
        for (int s = 0; s < 4; s++) begin
            step("R6", 1'b1, 2'd2, 2'(s), 4'd0, va, vb, '0);
            step("R6", 1'b1, 2'd2, 2'(s), 4'd0, rnd128(), rnd128(), '0);
            step("R7", 1'b1, 2'd3, 2'(s), 4'd0, va, vb, '0);
            step("R7", 1'b1, 2'd3, 2'(s), 4'd0, rnd128(), rnd128(), '0);
        end
        // R8: random control in fixed modes
        for (int i = 0; i < 12; i++)
            step("R8", 1'b1, 2'(1 + i % 3), 2'(i % 4), 4'(i), va, vb, rnd128());
        // R9: idle cycles with changing inputs
        for (int i = 0; i < 8; i++)
            step("R9", 1'b0, 2'(i % 4), 2'(i % 4), 4'(i), rnd128(), rnd128(), rnd128());
        // R10: back-to-back mixed stream, then interleaved gaps
        for (int i = 0; i < 40; i++)
            step("R10", (i % 7) != 3, 2'($urandom() % 4), 2'($urandom() % 4),
                 4'($urandom()), rnd128(), rnd128(), rnd128());
        step("R1", 1'b0, 2'd0, 2'd0, 4'd0, '0, '0, '0);
        step("R1", 1'b0, 2'd0, 2'd0, 4'd0, '0, '0, '0);
        @(negedge clk);
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule